// File: doc/BRIEF.md
# Interrupt Coalescing Unit with Micro-frame Threshold

This block produces the single interrupt request line of a bus host controller. It takes four kinds of event pulses. Two are transaction completions, one successful and one with an error. The other two are a root-port change and a host system error. Each event kind has its own sticky status bit. The interrupt line is raised when a status bit is set and its enable bit is also set.

Completion events are not reported at once. They are collected over an interval that is a programmable number of micro-frame ticks. The collected completions are moved into status only at the end of that interval. They move only if the status write-back for the most recent completed transaction has already been acknowledged. If that write-back is still outstanding at the boundary, the completions wait for a later boundary. Port-change and host-error events skip the interval and show up on the next clock.

Software uses a small register interface to clear status bits, set the enable mask and program the interval. The interval counter only advances while the controller's run control input is high.

Top module: `irq_coalesce`

## Requirements
- R1: After a synchronous reset, the status is 0, the enable mask is 0, the line is low, the interval is 8 ticks and the interval counter is 0.
- R2: A port-change pulse sets status bit 2 and a host-error pulse sets status bit 3, on the next clock edge, with no interval delay.
- R3: Completion pulses are held pending. The success pulse maps to status bit 0 and the error pulse to bit 1. They reach status only on a boundary, which is the clock on which the tick that completes the programmed number of ticks arrives while run is high.
- R4: A completion pulse marks a write-back as outstanding, and a write-back-done pulse clears that mark. If the mark is still set at a boundary, pending completions stay pending and are moved at the first later boundary where the mark is clear.
- R5: A write to address 2 sets the interval and restarts the counter. Values 1, 2, 4, 8, 16, 32 and 64 are accepted. Any other value, including one with bits set above bit 6, gives 8.
- R6: While run is low the counter holds, and ticks cause no boundary.
- R7: A write to address 0 clears each status bit whose data bit is 1 (write-1-to-clear). An event that sets a bit on the same clock wins over the clear.
- R8: A write to address 1 loads enable bits [3:0]. The line equals the OR of status ANDed with enable, and it changes on the same edge as status. A masked source still sets its status bit.
- R9: A completion that arrives on the boundary clock itself belongs to the next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Controller running; gates the interval counter |
| tick_i | input | 1 | Micro-frame tick pulse |
| ev_ok_i | input | 1 | Transaction completed successfully |
| ev_err_i | input | 1 | Transaction completed with error |
| ev_port_i | input | 1 | Root-port change event |
| ev_hse_i | input | 1 | Host system error event |
| wb_done_i | input | 1 | Status write-back acknowledged |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 2 | Register address: 0 status clear, 1 enable, 2 interval |
| csr_wdata_i | input | DW | Register write data |
| sts_o | output | 4 | Status bits: 0 success, 1 error, 2 port change, 3 host error |
| irq_o | output | 1 | Interrupt request line |

## Verification
The bench builds the block with the default parameters: 32-bit data, a largest interval of 64 and a reset interval of 8. These values let it reach both ends of the accepted interval range, 1 and 64 ticks, within a short run. They also let it test out-of-range writes that set bits above the counter width. Directed sequences cover each of these cases:
- a boundary with a write-back still outstanding;
- a completion landing on the boundary clock;
- a pause in the counter while run is low;
- a set and a clear arriving together.

A long random phase then mixes ticks, events, write-backs and register writes against the behavioural model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC     = 4;
  localparam int IDX_OK   = 0;
  localparam int IDX_ERR  = 1;
  localparam int IDX_PORT = 2;
  localparam int IDX_HSE  = 3;
  localparam logic [1:0] ADDR_STS = 2'd0;
  localparam logic [1:0] ADDR_IEN = 2'd1;
  localparam logic [1:0] ADDR_THR = 2'd2;
endpackage

// File: rtl/irq_thr_timer.sv
module irq_thr_timer #(
  parameter int DW      = 32,
  parameter int MAX_THR = 64,
  parameter int DEF_THR = 8,
  localparam int TW     = $clog2(MAX_THR) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          thr_we_i,
  input  logic [DW-1:0] thr_wdata_i,
  output logic          bnd_o
);
  logic [TW-1:0] thr_q, cnt_q, wr_v;
  logic          wr_ok;

  assign wr_v  = thr_wdata_i[TW-1:0];
  assign wr_ok = (thr_wdata_i[DW-1:TW] == '0) && ($countones(wr_v) == 1) &&
                 (wr_v <= TW'(MAX_THR));
  assign bnd_o = run_i && tick_i && (cnt_q == thr_q - TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= TW'(DEF_THR);
      cnt_q <= '0;
    end else begin
      if (thr_we_i) thr_q <= wr_ok ? wr_v : TW'(DEF_THR);
      if (thr_we_i || bnd_o)    cnt_q <= '0;
      else if (run_i && tick_i) cnt_q <= cnt_q + TW'(1);
    end
  end

  assert_cnt_below_thr_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q < thr_q);
  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !thr_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_cmpl_defer.sv
module irq_cmpl_defer (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_ok_i,
  input  logic       ev_err_i,
  input  logic       wb_done_i,
  input  logic       bnd_i,
  output logic [1:0] fire_o
);
  logic [1:0] pend_q;
  logic       busy_q, go;

  assign go     = bnd_i && !busy_q;
  assign fire_o = go ? pend_q : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 2'b00;
      busy_q <= 1'b0;
    end else begin
      pend_q <= (go ? 2'b00 : pend_q) | {ev_err_i, ev_ok_i};
      if (ev_ok_i || ev_err_i) busy_q <= 1'b1;
      else if (wb_done_i)      busy_q <= 1'b0;
    end
  end

  assert_busy_after_event_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_ok_i || ev_err_i) |=> busy_q);
  assert_hold_while_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && pend_q != 2'b00) |=> (pend_q != 2'b00));
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic            clr_we_i,
  input  logic            ien_we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] sts_o,
  output logic            irq_o
);
  logic [NSRC-1:0] sts_d, ien_q, ien_d;

  assign ien_d = ien_we_i ? wdata_i : ien_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    assign sts_d[i] = set_i[i] | (sts_o[i] & ~(clr_we_i & wdata_i[i]));
    always_ff @(posedge clk) begin
      if (rst) sts_o[i] <= 1'b0;
      else     sts_o[i] <= sts_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= '0;
      irq_o <= 1'b0;
    end else begin
      ien_q <= ien_d;
      irq_o <= |(sts_d & ien_d);
    end
  end

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(sts_o & ien_q));
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((sts_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
  import irq_pkg::*;
#(
  parameter int DW      = 32,
  parameter int MAX_THR = 64,
  parameter int DEF_THR = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          ev_ok_i,
  input  logic          ev_err_i,
  input  logic          ev_port_i,
  input  logic          ev_hse_i,
  input  logic          wb_done_i,
  input  logic          csr_we_i,
  input  logic [1:0]    csr_addr_i,
  input  logic [DW-1:0] csr_wdata_i,
  output logic [3:0]    sts_o,
  output logic          irq_o
);
  logic            bnd;
  logic [1:0]      fire;
  logic [NSRC-1:0] set;

  irq_thr_timer #(.DW(DW), .MAX_THR(MAX_THR), .DEF_THR(DEF_THR)) u_timer (
    .clk, .rst, .run_i, .tick_i,
    .thr_we_i   (csr_we_i && csr_addr_i == ADDR_THR),
    .thr_wdata_i(csr_wdata_i),
    .bnd_o      (bnd));

  irq_cmpl_defer u_defer (
    .clk, .rst, .ev_ok_i, .ev_err_i, .wb_done_i,
    .bnd_i (bnd),
    .fire_o(fire));

  always_comb begin
    set           = '0;
    set[IDX_OK]   = fire[0];
    set[IDX_ERR]  = fire[1];
    set[IDX_PORT] = ev_port_i;
    set[IDX_HSE]  = ev_hse_i;
  end

  irq_status #(.NSRC(NSRC)) u_status (
    .clk, .rst,
    .set_i   (set),
    .clr_we_i(csr_we_i && csr_addr_i == ADDR_STS),
    .ien_we_i(csr_we_i && csr_addr_i == ADDR_IEN),
    .wdata_i (csr_wdata_i[NSRC-1:0]),
    .sts_o   (sts_o),
    .irq_o   (irq_o));

  assert_cmpl_on_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(sts_o[IDX_OK]) || $rose(sts_o[IDX_ERR])) |-> $past(bnd));
  assert_port_fast_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_port_i || ev_hse_i) |=> (sts_o[IDX_PORT] || !$past(ev_port_i)) &&
                                (sts_o[IDX_HSE] || !$past(ev_hse_i)));
endmodule

// File: tb/tb_irq_coalesce.sv
`timescale 1ns/1ps
module tb_irq_coalesce;
  logic clk = 0, rst = 1, run = 0, tick = 0, ok = 0, er = 0, pc = 0, he = 0, wb = 0, we = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wd = 0;
  logic [3:0]  sts;
  logic        irq;
  int checks = 0, fails = 0;
  string tag = "R1";
  bit started = 0;

  always #4 clk = ~clk;

  irq_coalesce dut (
    .clk, .rst, .run_i(run), .tick_i(tick), .ev_ok_i(ok), .ev_err_i(er),
    .ev_port_i(pc), .ev_hse_i(he), .wb_done_i(wb), .csr_we_i(we),
    .csr_addr_i(addr), .csr_wdata_i(wd), .sts_o(sts), .irq_o(irq));

  // behavioural reference model
  int m_thr, m_cnt;
  bit [1:0] m_pend;
  bit m_busy, m_irq, m_bnd, m_fire;
  bit [3:0] m_sts, m_ien, m_set, m_clr;

  function automatic bit legal(input logic [31:0] v);
    return v inside {32'd1, 32'd2, 32'd4, 32'd8, 32'd16, 32'd32, 32'd64};
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_thr = 8; m_cnt = 0; m_pend = 0; m_busy = 0; m_sts = 0; m_ien = 0; m_irq = 0;
    end else begin
      m_bnd  = run && tick && (m_cnt == m_thr - 1);
      m_fire = m_bnd && !m_busy;
      m_set  = {he, pc, m_fire & m_pend[1], m_fire & m_pend[0]};
      m_clr  = (we && addr == 2'd0) ? wd[3:0] : 4'h0;
      m_sts  = (m_sts & ~m_clr) | m_set;
      if (we && addr == 2'd1) m_ien = wd[3:0];
      m_irq  = |(m_sts & m_ien);
      m_pend = (m_fire ? 2'b00 : m_pend) | {er, ok};
      if (ok || er) m_busy = 1; else if (wb) m_busy = 0;
      if (we && addr == 2'd2) begin m_thr = legal(wd) ? int'(wd) : 8; m_cnt = 0; end
      else if (m_bnd) m_cnt = 0;
      else if (run && tick) m_cnt++;
    end
  end

  always @(negedge clk) if (started) begin
    checks++;
    if (sts !== m_sts || irq !== m_irq) begin
      fails++;
      $display("FAIL %s model: sts=%h irq=%b expected sts=%h irq=%b", tag, sts, irq, m_sts, m_irq);
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic go(input bit t, input bit o, input bit e, input bit p, input bit h,
                    input bit w, input bit wr, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    tick = t; ok = o; er = e; pc = p; he = h; wb = w; we = wr; addr = a; wd = d;
  endtask
  task automatic idle(input int n);  repeat (n) go(0,0,0,0,0,0,0,0,0); endtask
  task automatic tickn(input int n); repeat (n) go(1,0,0,0,0,0,0,0,0); endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d); go(0,0,0,0,0,0,1,a,d); endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3); rst = 0; idle(1);
    chk({27'd0, irq, sts}, 32'h0, "R1 reset state");
    run = 1;
    tag = "R3";
    wr(1, 32'hF);
    go(0,1,0,0,0,0,0,0,0); go(0,0,0,0,0,1,0,0,0);
    tickn(7); idle(1); chk(sts, 0, "R3 before 8th tick (R1 default 8)");
    tickn(1); idle(1); chk({27'd0, irq, sts}, 32'h11, "R3 at boundary");
    tag = "R7";
    wr(0, 1); idle(1); chk({27'd0, irq, sts}, 32'h0, "R7 w1c");
    tag = "R2";
    go(0,0,0,1,0,0,0,0,0); idle(1); chk({27'd0, irq, sts}, 32'h14, "R2 port next cycle");
    wr(0, 4);
    tag = "R8";
    wr(1, 32'h7); go(0,0,0,0,1,0,0,0,0); idle(1);
    chk({27'd0, irq, sts}, 32'h08, "R8 masked hse latched, line low");
    wr(0, 8); wr(1, 32'hF);
    tag = "R5";
    wr(2, 2); go(0,0,1,0,0,0,0,0,0); go(0,0,0,0,0,1,0,0,0);
    tickn(2); idle(1); chk(sts, 2, "R5 interval 2");
    wr(0, 2);
    wr(2, 3); go(0,0,1,0,0,1,0,0,0); go(0,0,0,0,0,1,0,0,0);
    tickn(7); idle(1); chk(sts, 0, "R5 illegal 3 gives 8, before");
    tickn(1); idle(1); chk(sts, 2, "R5 illegal 3 gives 8, at boundary");
    wr(0, 2);
    wr(2, 32'h0000_0104); go(0,1,0,0,0,0,0,0,0); go(0,0,0,0,0,1,0,0,0);
    tickn(4); idle(1); chk(sts, 0, "R5 high bits illegal, not 4");
    tickn(4); idle(1); chk(sts, 1, "R5 high bits give 8");
    wr(0, 1);
    tag = "R4";
    wr(2, 4); go(0,1,0,0,0,0,0,0,0);
    tickn(4); idle(1); chk(sts, 0, "R4 deferred while write-back outstanding");
    go(0,0,0,0,0,1,0,0,0); tickn(4); idle(1); chk(sts, 1, "R4 next boundary");
    wr(0, 1);
    tag = "R6";
    wr(2, 4); go(0,1,0,0,0,0,0,0,0); go(0,0,0,0,0,1,0,0,0);
    tickn(2); idle(1); run = 0; tickn(10); idle(1); chk(sts, 0, "R6 hold while stopped");
    run = 1; tickn(1); idle(1); chk(sts, 0, "R6 counter resumed at 2");
    tickn(1); idle(1); chk(sts, 1, "R6 boundary after resume");
    wr(0, 1);
    tag = "R9";
    wr(2, 2); tickn(1); go(1,1,0,0,0,0,0,0,0); go(0,0,0,0,0,1,0,0,0); idle(1);
    chk(sts, 0, "R9 boundary-cycle completion deferred");
    tickn(2); idle(1); chk(sts, 1, "R9 reported next interval");
    wr(0, 1);
    tag = "R7";
    go(0,0,0,1,0,0,1,0,32'h4); idle(1); chk(sts, 4, "R7 set wins over clear");
    wr(0, 4);
    tag = "R5";
    wr(2, 1); go(0,1,0,0,0,0,0,0,0); go(0,0,0,0,0,1,0,0,0);
    tickn(1); idle(1); chk(sts, 1, "R5 interval 1");
    wr(0, 1);
    wr(2, 64); go(0,1,0,0,0,0,0,0,0); go(0,0,0,0,0,1,0,0,0);
    tickn(63); idle(1); chk(sts, 0, "R5 interval 64 before");
    tickn(1); idle(1); chk(sts, 1, "R5 interval 64 at boundary");
    wr(0, 1);
    tag = "R2 R3 R4 R7 R8 random";
    for (int i = 0; i < 4000; i++) begin
      run = ($urandom_range(0, 15) != 0);
      if ($urandom_range(0, 39) == 0)
        go(0,0,0,0,0,0,1, 2'($urandom_range(0, 3)), 32'($urandom_range(0, 70)));
      else
        go($urandom_range(0,1) == 1, $urandom_range(0,9) == 0, $urandom_range(0,14) == 0,
           $urandom_range(0,29) == 0, $urandom_range(0,39) == 0, $urandom_range(0,4) == 0,
           $urandom_range(0,9) == 0, 2'($urandom_range(0,1)), 32'($urandom_range(0,15)));
    end
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule